// File: doc/BRIEF.md
# I2C interrupt and DMA request controller

This block keeps one 16-bit control word for an I2C peripheral and turns the flags reported by the bit-level engine into four request lines: an event interrupt, an error interrupt, a DMA transmit request and a DMA receive request. Software writes the word through a simple write strobe and reads it back one cycle after a read strobe. Status flags arrive as plain levels from the engine, and flag-clearing is handled elsewhere.

The word also holds a 6-bit clock-frequency field and a last-transfer arm bit. In master receive mode the arm bit makes the block emit a single pulse toward the receiver logic when the DMA end-of-transfer arrives, so the final byte is answered with a NACK.

Top module: `i2c_irq_dma_ctrl`

## Requirements
- R1: After reset the word reads 0x0000. Bits 15:13 and 7:6 always read 0, and writing 1 to them has no effect.
- R2: The stored fields sit at these positions: bit 12 last-transfer arm, bit 11 DMA enable, bit 10 buffer interrupt enable, bit 9 event interrupt enable, bit 8 error interrupt enable, and bits 5:0 the frequency field. A read returns the stored fields on `rdata` in the cycle after `rd_en`.
- R3: `err_irq` is 1 only when the error enable (bit 8) is 1 and at least one bit of `err_flags` is 1.
- R4: When the event enable (bit 9) is 1, `evt_irq` asserts if any of start-sent, address-matched, 10-bit-header-sent or stop-detected is 1. With bit 9 at 0, `evt_irq` stays 0.
- R5: Byte-transfer-finished raises `evt_irq` (with bit 9 set) only while both transmit-empty and receive-not-empty are 0.
- R6: Transmit-empty and receive-not-empty raise `evt_irq` only when bits 10 and 9 are both 1, whatever the value of bit 11.
- R7: With bit 11 at 1, `dma_tx_req` follows transmit-empty and `dma_rx_req` follows receive-not-empty. With bit 11 at 0, both stay 0.
- R8: `nack_last` pulses high for one cycle when `dma_eot` is seen while bits 12 and 11 are both 1. The pulse does not repeat for later end-of-transfer inputs until bit 12 is written with 1 again.
- R9: All four request outputs are registered. They change one clock after a flag input changes, and two clocks after the write strobe that changes an enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| rd_en | input | 1 | Read strobe for the control word |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |
| fl_start | input | 1 | Start condition sent |
| fl_addr | input | 1 | Address matched or sent |
| fl_hdr10 | input | 1 | 10-bit header sent |
| fl_stop | input | 1 | Stop condition detected |
| fl_byte_done | input | 1 | Byte transfer finished |
| fl_tx_empty | input | 1 | Transmit data register empty |
| fl_rx_full | input | 1 | Receive data register not empty |
| err_flags | input | 7 | Error conditions, any bit set is an error |
| dma_eot | input | 1 | DMA end of transfer |
| evt_irq | output | 1 | Event interrupt |
| err_irq | output | 1 | Error interrupt |
| dma_tx_req | output | 1 | DMA transmit request |
| dma_rx_req | output | 1 | DMA receive request |
| nack_last | output | 1 | One-cycle pulse: answer the final byte with NACK |

## Verification
A corrupted enable bit shows up at the ports in two ways. A read returns the wrong value one cycle after the strobe, and the request line it gates goes wrong two cycles after the write. If the priority between the byte-done flag and the buffer flags is wrong, `evt_irq` stays high while software expects it to drop, which is visible one clock after a buffer flag rises with the buffer enable off. If the last-transfer arm state is stale, `nack_last` either pulses twice across consecutive end-of-transfer inputs or never pulses after a rewrite, and this is seen one clock after `dma_eot`.

// File: rtl/i2c_irq_dma_ctrl.sv
module i2c_irq_dma_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        fl_start,
  input  logic        fl_addr,
  input  logic        fl_hdr10,
  input  logic        fl_stop,
  input  logic        fl_byte_done,
  input  logic        fl_tx_empty,
  input  logic        fl_rx_full,
  input  logic [6:0]  err_flags,
  input  logic        dma_eot,
  output logic        evt_irq,
  output logic        err_irq,
  output logic        dma_tx_req,
  output logic        dma_rx_req,
  output logic        nack_last
);
  logic       last_arm, dma_on, buf_ie, evt_ie, err_ie;
  logic [5:0] freq_mhz;
  logic       armed;

  wire [15:0] word = {3'b000, last_arm, dma_on, buf_ie, evt_ie, err_ie, 2'b00, freq_mhz};
  wire buf_flag    = fl_tx_empty | fl_rx_full;
  wire evt_src     = fl_start | fl_addr | fl_hdr10 | fl_stop
                   | (fl_byte_done & ~buf_flag)
                   | (buf_ie & buf_flag);
  wire nack_fire   = dma_eot & armed & last_arm & dma_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {last_arm, dma_on, buf_ie, evt_ie, err_ie} <= '0;
      freq_mhz <= '0;
    end else if (wr_en) begin
      {last_arm, dma_on, buf_ie, evt_ie, err_ie} <= wdata[12:8];
      freq_mhz <= wdata[5:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   armed <= 1'b0;
    else if (wr_en && wdata[12])  armed <= 1'b1;
    else if (nack_fire)           armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_irq    <= 1'b0;
      err_irq    <= 1'b0;
      dma_tx_req <= 1'b0;
      dma_rx_req <= 1'b0;
      nack_last  <= 1'b0;
    end else begin
      evt_irq    <= evt_ie & evt_src;
      err_irq    <= err_ie & (|err_flags);
      dma_tx_req <= dma_on & fl_tx_empty;
      dma_rx_req <= dma_on & fl_rx_full;
      nack_last  <= nack_fire;
    end
  end
endmodule

module i2c_irq_dma_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] rdata,
  input logic        err_ie,
  input logic        evt_ie,
  input logic        dma_on,
  input logic [6:0]  err_flags,
  input logic        fl_tx_empty,
  input logic        fl_rx_full,
  input logic        evt_irq,
  input logic        err_irq,
  input logic        dma_tx_req,
  input logic        dma_rx_req,
  input logic        nack_last
);
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[15:13] == 3'b000 && rdata[7:6] == 2'b00);
  p_err_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> $past(err_ie && (|err_flags)));
  p_evt_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_irq |-> $past(evt_ie));
  p_dma_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tx_req |-> $past(dma_on && fl_tx_empty));
  p_dma_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_req |-> $past(dma_on && fl_rx_full));
  p_nack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nack_last |=> !nack_last);
endmodule

bind i2c_irq_dma_ctrl i2c_irq_dma_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rdata(rdata), .err_ie(err_ie), .evt_ie(evt_ie),
  .dma_on(dma_on), .err_flags(err_flags), .fl_tx_empty(fl_tx_empty),
  .fl_rx_full(fl_rx_full), .evt_irq(evt_irq), .err_irq(err_irq),
  .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .nack_last(nack_last));

// File: tb/i2c_irq_dma_ctrl_tb.sv
module i2c_irq_dma_ctrl_tb;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic fl_start = 0, fl_addr = 0, fl_hdr10 = 0, fl_stop = 0;
  logic fl_byte_done = 0, fl_tx_empty = 0, fl_rx_full = 0, dma_eot = 0;
  logic [6:0] err_flags = 0;
  logic evt_irq, err_irq, dma_tx_req, dma_rx_req, nack_last;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  i2c_irq_dma_ctrl u_dut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(logic [15:0] v);
    wdata = v; wr_en = 1; step(); wr_en = 0;
  endtask

  task automatic rd(string req, logic [15:0] exp);
    rd_en = 1; step(); rd_en = 0;
    chk(req, rdata, exp);
  endtask

  task automatic clr_flags();
    {fl_start, fl_addr, fl_hdr10, fl_stop, fl_byte_done, fl_tx_empty, fl_rx_full} = '0;
    err_flags = 0; dma_eot = 0;
  endtask

  task automatic t_reset();
    rd("R1 reset", 16'h0000);
    chk("R1 outputs idle", {11'd0, evt_irq, err_irq, dma_tx_req, dma_rx_req, nack_last}, 16'h0);
  endtask

  task automatic t_regs();
    wr(16'hFFFF); rd("R1 reserved ignored", 16'h1F3F);
    wr(16'h0A15); rd("R2 fields", 16'h0A15);
    wr(16'h0000); rd("R2 clear", 16'h0000);
  endtask

  task automatic t_err();
    err_flags = 7'h40; step();
    chk("R3 disabled", err_irq, 0);
    wr(16'h0100); step();
    chk("R3 enabled", err_irq, 1);
    err_flags = 7'h00; step();
    chk("R3 cleared", err_irq, 0);
    err_flags = 7'h01; step();
    chk("R3 other bit", err_irq, 1);
    clr_flags(); wr(16'h0000); step();
  endtask

  task automatic t_evt();
    fl_stop = 1; step();
    chk("R4 disabled", evt_irq, 0);
    wr(16'h0200);
    chk("R9 enable two cycles", evt_irq, 0);
    step();
    chk("R4 stop", evt_irq, 1);
    fl_stop = 0; fl_hdr10 = 1; step();
    chk("R4 hdr10", evt_irq, 1);
    fl_hdr10 = 0; #1;
    chk("R9 registered hold", evt_irq, 1);
    step();
    chk("R9 falls one clock", evt_irq, 0);
    clr_flags(); step();
  endtask

  task automatic t_btf();
    wr(16'h0200);
    fl_byte_done = 1; step();
    chk("R5 btf alone", evt_irq, 1);
    fl_tx_empty = 1; step();
    chk("R5 btf masked by txe", evt_irq, 0);
    fl_tx_empty = 0; fl_rx_full = 1; step();
    chk("R5 btf masked by rxne", evt_irq, 0);
    clr_flags(); step();
  endtask

  task automatic t_buf();
    wr(16'h0600);
    fl_rx_full = 1; step();
    chk("R6 rxne buf on", evt_irq, 1);
    wr(16'h0E00); step();
    chk("R6 with dma on", evt_irq, 1);
    wr(16'h0400); step();
    chk("R6 needs evt enable", evt_irq, 0);
    clr_flags(); wr(16'h0000); step();
  endtask

  task automatic t_dma();
    fl_tx_empty = 1; fl_rx_full = 1; step();
    chk("R7 off", {dma_tx_req, dma_rx_req}, 2'b00);
    wr(16'h0800); step();
    chk("R7 on", {dma_tx_req, dma_rx_req}, 2'b11);
    fl_tx_empty = 0; step();
    chk("R7 tx follows", {dma_tx_req, dma_rx_req}, 2'b01);
    clr_flags(); wr(16'h0000); step();
  endtask

  task automatic t_nack();
    dma_eot = 1; step();
    chk("R8 not armed", nack_last, 0);
    dma_eot = 0; wr(16'h1800);
    dma_eot = 1; step();
    chk("R8 pulse", nack_last, 1);
    step();
    chk("R8 single cycle", nack_last, 0);
    dma_eot = 0; step(); dma_eot = 1; step();
    chk("R8 no repeat", nack_last, 0);
    dma_eot = 0; wr(16'h1800);
    dma_eot = 1; step();
    chk("R8 rearmed", nack_last, 1);
    dma_eot = 0; wr(16'h1000);
    dma_eot = 1; step();
    chk("R8 needs dma enable", nack_last, 0);
    clr_flags(); wr(16'h0000); step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; step();
    t_reset(); t_regs(); t_err(); t_evt(); t_btf(); t_buf(); t_dma(); t_nack();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule